// File: doc/BRIEF.md
# Debounced Pushbutton Reset Generator

This block produces a supervisory system reset from two causes: a manual pushbutton wired active-low, and a supply-in-tolerance flag coming from an analog monitor. Both inputs arrive asynchronously and are passed through two-flop synchronizers. The pushbutton is debounced against a 1 ms tick enable. A low level counts as a press only once it has been held without a break for a parameterised number of ticks. Any shorter low, including contact bounce, is discarded.

While a press is accepted or the supply flag is false, reset is driven. The block drives the reset at both polarities and also exports a reset-active flag for neighbouring logic. When the last cause goes away, a single stretch counter holds the reset for a further parameterised number of ticks. If a cause returns before that count completes, the counter is cleared and the full interval starts again from the next release. Reset is also asserted from the system reset and stays asserted until one full stretch has completed.

Top module: `pbrst_gen`

## Requirements
- R1: While the synchronous system reset `rst_n` is low, `rst_hi` and `rst_active` read 1 and `rst_lo_n` reads 0.
- R2: A pushbutton low (`pb_n` = 0) that lasts fewer than `DEB_TICKS` tick cycles after synchronization never asserts reset, even when repeated with bounce.
- R3: A pushbutton low that is held through `DEB_TICKS` ticks is accepted. With a tick every cycle, reset asserts at the 23rd clock edge after `pb_n` falls (two synchronizer edges, twenty counting edges, one output register edge).
- R4: Reset stays asserted for as long as an accepted press is held low.
- R5: After an accepted press releases, reset stays asserted for `STRETCH_TICKS` ticks. With a tick every cycle, it releases at the 253rd edge after `pb_n` rises.
- R6: While `pwr_ok` is 0, reset is asserted. After `pwr_ok` returns to 1, reset stays asserted for `STRETCH_TICKS` ticks. With a tick every cycle, it releases at the 252nd edge.
- R7: `rst_hi` and `rst_active` are always equal, and `rst_lo_n` is always their complement.
- R8: If a cause re-asserts during the stretch interval, the stretch count restarts, and the full interval is counted again from the next release.
- R9: After `rst_n` releases with `pwr_ok` = 1 and `pb_n` = 1, reset is held until one full stretch has completed, which is 252 edges with a tick every cycle.
- R10: Outside the tick enable, no debounce or stretch progress is made. Timing is measured in ticks, not clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| tick_ms | input | 1 | One-cycle 1 ms timing enable |
| pb_n | input | 1 | Asynchronous pushbutton, low when pressed |
| pwr_ok | input | 1 | Asynchronous supply-in-tolerance flag, 1 when good |
| rst_hi | output | 1 | Reset out, active high |
| rst_lo_n | output | 1 | Reset out, active low |
| rst_active | output | 1 | Reset-active flag for other logic |

## Verification
Directed presses of 19 ticks, and repeated bounce bursts of short lows, separate a rejected glitch from a press accepted at exactly the debounce boundary. The exact release edge is measured three ways: after a button release, after supply recovery, and after the system reset. Each measurement shows whether the stretch restarts on release or on the original press. A second press during an active stretch shows that the count restarts rather than carries over. Random bouncing button traffic with sparse ticks and occasional supply dips is compared cycle by cycle against a bench reference model. This exposes wrong behaviour when ticks are absent and when the two causes overlap.

// File: rtl/pbr_pkg.sv
// Package: shared constants for the pushbutton reset generator.
// Assumes: the two-stage synchronizer depth is fixed project-wide.
package pbr_pkg;
    localparam int unsigned SYNC_STAGES = 2;

    // Counter width able to hold values 0..n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/pbr_sync.sv
// Module: multi-bit synchronizer, one independent flop chain per bit.
// Assumes: each bit is an unrelated level; RST_VAL gives the safe value
// per bit that is loaded during synchronous reset.
module pbr_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    import pbr_pkg::*;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [SYNC_STAGES-1:0] chain;

        // Shift the asynchronous level through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {SYNC_STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], d[b]};
            end
        end

        assign q[b] = chain[SYNC_STAGES-1];
    end
endmodule

// File: rtl/pbr_debounce.sv
// Module: accepts a low level on a synchronized pushbutton only after it has
// been low for DEB_TICKS tick enables without a break.
// Assumes: btn_n_s is already synchronous; tick is a one-cycle enable.
module pbr_debounce #(
    parameter int unsigned DEB_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_n_s,
    output logic pressed
);
    import pbr_pkg::*;
    localparam int unsigned CW = cnt_width(DEB_TICKS);
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    logic [CW-1:0] low_cnt;

    // Count ticks of continuous low; any high level clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            pressed <= 1'b0;
        end else if (btn_n_s) begin
            low_cnt <= '0;
            pressed <= 1'b0;
        end else if (tick && !pressed) begin
            if (low_cnt == LAST) begin
                pressed <= 1'b1;
            end else begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    // R2: acceptance needs the button low on the edge it is accepted
    p_accept_needs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pressed) |-> ($past(btn_n_s) == 1'b0 && $past(tick)));

    // R4: a released button drops the accepted press on the next edge
    p_release_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        btn_n_s |=> !pressed);

    // R10: the count never moves without a tick while the button stays low
    p_tick_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !btn_n_s) |=> $stable(low_cnt));
endmodule

// File: rtl/pbr_stretch.sv
// Module: holds reset while any cause is present and for STRETCH_TICKS ticks
// after the last cause releases; a returning cause restarts the count.
// Assumes: cause is synchronous; tick is a one-cycle enable.
module pbr_stretch #(
    parameter int unsigned STRETCH_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cause,
    output logic act_hi,
    output logic act_lo_n
);
    import pbr_pkg::*;
    localparam int unsigned CW = cnt_width(STRETCH_TICKS);
    localparam logic [CW-1:0] LAST = CW'(STRETCH_TICKS - 1);

    logic [CW-1:0] hold_cnt;
    logic          act_nxt;
    logic [CW-1:0] cnt_nxt;

    // Next-state for the stretch: reload on cause, count down the window.
    always_comb begin
        act_nxt = act_hi;
        cnt_nxt = hold_cnt;
        if (cause) begin
            act_nxt = 1'b1;
            cnt_nxt = '0;
        end else if (act_hi && tick) begin
            if (hold_cnt == LAST) begin
                act_nxt = 1'b0;
                cnt_nxt = '0;
            end else begin
                cnt_nxt = hold_cnt + 1'b1;
            end
        end
    end

    // Register both polarities in separate flops so neither is a gate late.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            act_hi   <= 1'b1;
            act_lo_n <= 1'b0;
        end else begin
            hold_cnt <= cnt_nxt;
            act_hi   <= act_nxt;
            act_lo_n <= !act_nxt;
        end
    end

    // R4 / R6: any cause forces reset on the following edge
    p_cause_asserts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> (act_hi && !act_lo_n));

    // R7: the two polarity flops never disagree
    p_polarity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_hi != act_lo_n);

    // R8: a cause restarts the stretch window from zero
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> (hold_cnt == '0));

    // R5: release only on a tick, with no cause, at the end of the window
    p_release_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act_hi) |-> ($past(tick) && !$past(cause) && $past(hold_cnt) == LAST));

    // R5: the counter stays inside its window
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= LAST);
endmodule

// File: rtl/pbrst_gen.sv
// Module: top of the pushbutton and supply-fault reset generator.
// Assumes: pb_n and pwr_ok are asynchronous levels; tick_ms pulses for one
// clock once per millisecond; rst_n is synchronous to clk.
module pbrst_gen #(
    parameter int unsigned DEB_TICKS     = 20,
    parameter int unsigned STRETCH_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic pb_n,
    input  logic pwr_ok,
    output logic rst_hi,
    output logic rst_lo_n,
    output logic rst_active
);
    logic [1:0] raw_in;
    logic [1:0] sync_in;
    logic       pb_n_s;
    logic       pwr_ok_s;
    logic       pressed;
    logic       cause;

    // Bit 1 is the button (safe released = 1), bit 0 the supply (safe bad = 0).
    assign raw_in = {pb_n, pwr_ok};

    pbr_sync #(
        .WIDTH   (2),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    assign pb_n_s   = sync_in[1];
    assign pwr_ok_s = sync_in[0];

    pbr_debounce #(
        .DEB_TICKS (DEB_TICKS)
    ) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_ms),
        .btn_n_s (pb_n_s),
        .pressed (pressed)
    );

    // Either an accepted press or a supply fault is a reset cause.
    assign cause = pressed || !pwr_ok_s;

    pbr_stretch #(
        .STRETCH_TICKS (STRETCH_TICKS)
    ) u_str (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_ms),
        .cause    (cause),
        .act_hi   (rst_hi),
        .act_lo_n (rst_lo_n)
    );

    assign rst_active = rst_hi;

    // R1: reset is asserted on the edge after a system reset cycle
    p_sysrst_r1: assert property (@(posedge clk)
        !rst_n |=> (rst_hi && !rst_lo_n));

    // R6: a synchronized supply fault keeps reset asserted
    p_supply_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_ok_s && $past(!pwr_ok_s)) |-> rst_hi);
endmodule

// File: tb/pbrst_gen_tb.sv
module pbrst_gen_tb;
    localparam int DEB = 20;
    localparam int STR = 250;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b1;
    logic pb_n = 1'b1;
    logic pwr_ok = 1'b1;
    logic rst_hi, rst_lo_n, rst_active;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pbrst_gen #(.DEB_TICKS(DEB), .STRETCH_TICKS(STR)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pb_n(pb_n),
        .pwr_ok(pwr_ok), .rst_hi(rst_hi), .rst_lo_n(rst_lo_n),
        .rst_active(rst_active)
    );

    // Reference model built from the requirements.
    logic m_pb1, m_pb2, m_pw1, m_pw2, m_pr, m_act;
    int   m_dc, m_sc;

    function automatic logic model_cause(input logic pr, input logic pw);
        return pr || !pw;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pb1 <= 1; m_pb2 <= 1; m_pw1 <= 0; m_pw2 <= 0;
            m_dc <= 0; m_pr <= 0; m_act <= 1; m_sc <= 0;
        end else begin
            m_pb1 <= pb_n; m_pb2 <= m_pb1;
            m_pw1 <= pwr_ok; m_pw2 <= m_pw1;
            if (m_pb2) begin
                m_dc <= 0; m_pr <= 0;
            end else if (tick_ms && !m_pr) begin
                if (m_dc == DEB - 1) m_pr <= 1;
                else m_dc <= m_dc + 1;
            end
            if (model_cause(m_pr, m_pw2)) begin
                m_act <= 1; m_sc <= 0;
            end else if (m_act && tick_ms) begin
                if (m_sc == STR - 1) begin m_act <= 0; m_sc <= 0; end
                else m_sc <= m_sc + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model; R7 polarity every cycle.
    int model_fails = 0;
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rst_hi !== m_act || rst_lo_n !== !m_act || rst_active !== m_act) begin
                errors++;
                if (model_fails < 10)
                    $display("FAIL R7 model: actual hi=%0b lo_n=%0b act=%0b expected hi=%0b",
                             rst_hi, rst_lo_n, rst_active, m_act);
                model_fails++;
            end
        end
    end

    // Count negedges until rst_hi drops, bounded.
    task automatic time_to_release(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_hi && n < 5000);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: an expired run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        int seed_dummy;
        seed_dummy = $urandom(1234);
        wait_cycles(3);
        // R1: reset state
        check("R1 rst_hi", rst_hi, 1);
        check("R1 rst_lo_n", rst_lo_n, 0);
        check("R1 rst_active", rst_active, 1);

        // R9: hold after system reset for one full stretch
        rst_n = 1'b1;
        time_to_release(n);
        check("R9 post-reset release edge", n, 2 + STR);

        // R2: a press one tick short of the debounce is ignored
        wait_cycles(5);
        pb_n = 1'b0;
        wait_cycles(DEB - 1);
        pb_n = 1'b1;
        wait_cycles(30);
        check("R2 short press", rst_hi, 0);

        // R2: bounce bursts of short lows
        for (int k = 0; k < 6; k++) begin
            pb_n = 1'b0; wait_cycles(3 + k);
            pb_n = 1'b1; wait_cycles(2);
        end
        wait_cycles(30);
        check("R2 bounce", rst_hi, 0);
        check("R2 bounce lo_n", rst_lo_n, 1);

        // R3: accepted at the 23rd edge
        pb_n = 1'b0;
        wait_cycles(22);
        check("R3 before accept", rst_hi, 0);
        wait_cycles(1);
        check("R3 accept edge", rst_hi, 1);
        // R4: held while low
        wait_cycles(300);
        check("R4 held while low", rst_hi, 1);
        check("R7 lo_n while held", rst_lo_n, 0);
        // R5: release 253 edges after button rise
        pb_n = 1'b1;
        time_to_release(n);
        check("R5 release edge", n, 3 + STR);

        // R6: supply fault then recovery
        wait_cycles(10);
        pwr_ok = 1'b0;
        wait_cycles(4);
        check("R6 fault asserts", rst_hi, 1);
        pwr_ok = 1'b1;
        time_to_release(n);
        check("R6 recovery release edge", n, 2 + STR);

        // R8: second press during stretch restarts the window
        wait_cycles(10);
        pb_n = 1'b0; wait_cycles(40);
        pb_n = 1'b1; wait_cycles(100);
        check("R8 mid-stretch still active", rst_hi, 1);
        pb_n = 1'b0; wait_cycles(40);
        pb_n = 1'b1;
        time_to_release(n);
        check("R8 restart release edge", n, 3 + STR);

        // R10: no ticks means no progress
        wait_cycles(10);
        tick_ms = 1'b0;
        pb_n = 1'b0; wait_cycles(100);
        check("R10 no tick no accept", rst_hi, 0);
        tick_ms = 1'b1; wait_cycles(DEB + 2);
        check("R10 tick resumes accept", rst_hi, 1);
        pb_n = 1'b1; wait_cycles(5);
        tick_ms = 1'b0; wait_cycles(600);
        check("R10 stretch frozen", rst_hi, 1);
        tick_ms = 1'b1;
        wait_cycles(STR + 5);
        check("R5 released after resume", rst_hi, 0);

        // Random bouncing traffic with sparse ticks, checked by the model.
        for (int seg = 0; seg < 80; seg++) begin
            int len;
            len = 1 + int'($urandom % 45);
            pb_n = $urandom % 2;
            if ($urandom % 10 == 0) pwr_ok = 1'b0;
            else pwr_ok = 1'b1;
            for (int c = 0; c < len; c++) begin
                tick_ms = ($urandom % 3 == 0);
                wait_cycles(1);
            end
        end
        pb_n = 1'b1; pwr_ok = 1'b1; tick_ms = 1'b1;
        wait_cycles(STR + 10);
        check("R5 random final release", rst_hi, 0);

        // R1: reset mid-run asserts again
        rst_n = 1'b0;
        wait_cycles(2);
        check("R1 mid-run reset", rst_hi, 1);
        rst_n = 1'b1;
        time_to_release(n);
        check("R9 second post-reset", n, 2 + STR);

        finish_run();
    end
endmodule